// File: doc/BRIEF.md
# External I/O Bank Controller

This block turns requests from an internal bus into timed strobe cycles for slow peripherals on two external I/O banks. Each bank has two active-low chip selects, a data width of 8 or 16 bits chosen by a configuration pin, and its own three timing fields. The fields set the address setup before the strobe, the minimum strobe width, and the hold time after the strobe. A peripheral that needs more time raises the wait input. The controller brings that input into its clock domain and keeps the strobe active for as long as the input stays high.

On the internal side the request channel is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so a request that arrives during an access stays pending until the access is over. The response channel is also valid/ready. `rsp_valid` stays high, and `rsp_rdata` stays unchanged, until the edge where `rsp_ready` is seen high. No new request is taken before that edge. A wide access to a narrower bank is carried out as several consecutive beats. The chip select stays low from the first beat to the last.

Top module: `eio_bank_ctrl`

## Requirements
- R1: While `rst_n` is low, all chip selects and both strobes are high (inactive), `io_doe` and `rsp_valid` are low, and `req_ready` is high.
- R2: During an access exactly one chip select is low. Its index is 2*b + c, where b is `req_addr[BANK_BIT]` and c is `req_addr[CS_BIT]`. All chip selects are high while the controller is idle or responding.
- R3: Every beat has three phases in order. Setup lasts S+1 cycles with the chip select low and both strobes high. The strobe phase lasts at least W+1 cycles. Hold lasts H+1 cycles with both strobes high. S, W and H are the 3-bit fields of the addressed bank: bank b uses bits [3b+2:3b] of `cfg_setup`, `cfg_strobe` and `cfg_hold`.
- R4: `io_wait` passes through a two-flop synchronizer. Once the minimum strobe width has elapsed, the strobe stays low on every cycle in which the synchronized wait is high.
- R5: A bank with `cfg_wide[b]`=0 is 8 bits wide. On such a bank an access of size code 0 (byte), 1 (half) or 2/3 (word) takes 1, 2 or 4 byte beats. Beat k uses address base+k and carries write byte k (`req_wdata[8k+7:8k]`) on both `io_dout` lanes.
- R6: A bank with `cfg_wide[b]`=1 is 16 bits wide. On such a bank a byte or half access is one beat at the base address, and a word access is two beats at base and base+2, low half first. A byte write puts the byte on both lanes. A byte read takes `io_din[15:8]` when address bit 0 is 1 and `io_din[7:0]` otherwise.
- R7: Read data is sampled from `io_din` on the last cycle of each beat's strobe. It is assembled little-endian, byte k at bits 8k (half k at bits 16k on a 16-bit bank), with unused upper bits zero. A write response returns zero.
- R8: `req_ready` is high only when idle. `rsp_valid` rises after the final hold cycle and stays high with stable `rsp_rdata` until `rsp_ready`. No request is accepted while the response is pending.
- R9: `io_rd_n` goes low only during the strobe phase of a read, and `io_wr_n` only during the strobe phase of a write. `io_doe` is high through the setup, strobe and hold phases of writes and low at all other times.
- R10: The bank width and the timing fields are captured when a request is accepted. Changing the configuration pins during an access has no effect on that access.
- R11: `io_addr` holds the current beat address through the setup, strobe and hold phases of that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | AW | Byte address; bit BANK_BIT picks the bank, bit CS_BIT the chip select |
| req_size | input | 2 | 0 byte, 1 half, 2 or 3 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Access finished, response held |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Assembled read data, zero for writes |
| cfg_wide | input | 2 | Per bank: 1 = 16-bit, 0 = 8-bit |
| cfg_setup | input | 2*TW | Per-bank setup cycles minus one |
| cfg_strobe | input | 2*TW | Per-bank minimum strobe cycles minus one |
| cfg_hold | input | 2*TW | Per-bank hold cycles minus one |
| io_addr | output | AW | External beat address |
| io_cs_n | output | 4 | Active-low chip selects |
| io_rd_n | output | 1 | Active-low read strobe |
| io_wr_n | output | 1 | Active-low write strobe |
| io_dout | output | 16 | Write data lanes |
| io_doe | output | 1 | Drive enable for io_dout |
| io_din | input | 16 | Read data lanes |
| io_wait | input | 1 | Asynchronous stretch request, active high |

## Verification
The bench builds the controller with AW=12, BANK_BIT=11 and CS_BIT=10. With these values all four chip selects can be reached with short addresses, and the peripheral model can derive read data from the low address byte. TW keeps its default of 3. This lets the bench drive each timing field to both ends of its range, 1 and 8 clocks, and exercise a word split into four byte beats at the widest timing. The peripheral drives a marker value whenever the read strobe is high. A capture taken outside the strobe therefore returns wrong data.

// File: rtl/eio_pkg.sv
package eio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RESP   = 3'd4
  } phase_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam int NUM_BANKS   = 2;
  localparam int CS_PER_BANK = 2;
  localparam int LANE_W      = 16;
  localparam int WORD_W      = 32;

endpackage

// File: rtl/eio_wait_sync.sv
module eio_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/eio_beat_plan.sv
module eio_beat_plan import eio_pkg::*; #(
  parameter int AW = 21
) (
  input  logic              wide,
  input  logic [1:0]        size,
  input  logic [AW-1:0]     base,
  input  logic [1:0]        beat,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANE_W-1:0] din,
  output logic [2:0]        nbeats,
  output logic [AW-1:0]     beat_addr,
  output logic [LANE_W-1:0] beat_wdata,
  output logic [WORD_W-1:0] rd_piece
);

  logic [7:0] byte_k;

  always_comb begin
    byte_k = wdata[{beat, 3'b000} +: 8];
    if (!wide) begin
      // narrow bank: one byte beat per byte, ascending
      nbeats     = (size == SZ_BYTE) ? 3'd1 : (size == SZ_HALF) ? 3'd2 : 3'd4;
      beat_addr  = base + AW'(beat);
      beat_wdata = {byte_k, byte_k};
      rd_piece   = WORD_W'(din[7:0]) << {beat, 3'b000};
    end else begin
      unique case (size)
        SZ_BYTE: begin
          nbeats     = 3'd1;
          beat_addr  = base;
          beat_wdata = {wdata[7:0], wdata[7:0]};
          rd_piece   = WORD_W'(base[0] ? din[15:8] : din[7:0]);
        end
        SZ_HALF: begin
          nbeats     = 3'd1;
          beat_addr  = base;
          beat_wdata = wdata[15:0];
          rd_piece   = WORD_W'(din);
        end
        default: begin
          nbeats     = 3'd2;
          beat_addr  = base + AW'({beat, 1'b0});
          beat_wdata = beat[0] ? wdata[31:16] : wdata[15:0];
          rd_piece   = WORD_W'(din) << (beat[0] ? 5'd16 : 5'd0);
        end
      endcase
    end
  end

endmodule

// File: rtl/eio_cs_decode.sv
module eio_cs_decode #(
  parameter int NUM_CS = 4,
  localparam int SELW  = $clog2(NUM_CS)
) (
  input  logic            active,
  input  logic [SELW-1:0] sel,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(active && (sel == SELW'(g)));
  end

endmodule

// File: rtl/eio_bank_ctrl.sv
module eio_bank_ctrl import eio_pkg::*; #(
  parameter int AW       = 21,
  parameter int BANK_BIT = 20,
  parameter int CS_BIT   = 19,
  parameter int TW       = 3,
  localparam int NCS     = NUM_BANKS * CS_PER_BANK,
  localparam int SELW    = $clog2(NCS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_addr,
  input  logic [1:0]              req_size,
  input  logic                    req_write,
  input  logic [WORD_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [WORD_W-1:0]       rsp_rdata,
  input  logic [NUM_BANKS-1:0]    cfg_wide,
  input  logic [NUM_BANKS*TW-1:0] cfg_setup,
  input  logic [NUM_BANKS*TW-1:0] cfg_strobe,
  input  logic [NUM_BANKS*TW-1:0] cfg_hold,
  output logic [AW-1:0]           io_addr,
  output logic [NCS-1:0]          io_cs_n,
  output logic                    io_rd_n,
  output logic                    io_wr_n,
  output logic [LANE_W-1:0]       io_dout,
  output logic                    io_doe,
  input  logic [LANE_W-1:0]       io_din,
  input  logic                    io_wait
);

  // per-bank timing fields unpacked
  logic [TW-1:0] setup_a  [NUM_BANKS];
  logic [TW-1:0] strobe_a [NUM_BANKS];
  logic [TW-1:0] hold_a   [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign setup_a[b]  = cfg_setup[b*TW +: TW];
    assign strobe_a[b] = cfg_strobe[b*TW +: TW];
    assign hold_a[b]   = cfg_hold[b*TW +: TW];
  end

  phase_e              phase_q;
  logic [TW-1:0]       cnt_q;
  logic [1:0]          beat_q;
  logic [AW-1:0]       addr_q;
  logic [1:0]          size_q;
  logic                we_q;
  logic                wide_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [SELW-1:0]     sel_q;
  logic [TW-1:0]       tsu_q, tst_q, tho_q;
  logic [WORD_W-1:0]   rdata_q;

  logic                wait_s;
  logic [2:0]          nbeats;
  logic [AW-1:0]       beat_addr;
  logic [LANE_W-1:0]   beat_wdata;
  logic [WORD_W-1:0]   rd_piece;
  logic                active;
  logic                last_beat;
  logic                bank_in;

  eio_wait_sync #(.STAGES(2)) u_wait_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (io_wait),
    .sync_out (wait_s)
  );

  eio_beat_plan #(.AW(AW)) u_plan (
    .wide       (wide_q),
    .size       (size_q),
    .base       (addr_q),
    .beat       (beat_q),
    .wdata      (wdata_q),
    .din        (io_din),
    .nbeats     (nbeats),
    .beat_addr  (beat_addr),
    .beat_wdata (beat_wdata),
    .rd_piece   (rd_piece)
  );

  assign active    = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
  assign last_beat = (({1'b0, beat_q} + 3'd1) == nbeats);
  assign bank_in   = req_addr[BANK_BIT];

  eio_cs_decode #(.NUM_CS(NCS)) u_cs (
    .active (active),
    .sel    (sel_q),
    .cs_n   (io_cs_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      wdata_q <= '0;
      sel_q   <= '0;
      tsu_q   <= '0;
      tst_q   <= '0;
      tho_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            size_q  <= req_size;
            we_q    <= req_write;
            wdata_q <= req_wdata;
            wide_q  <= cfg_wide[bank_in];
            sel_q   <= SELW'({bank_in, req_addr[CS_BIT]});
            tsu_q   <= setup_a[bank_in];
            tst_q   <= strobe_a[bank_in];
            tho_q   <= hold_a[bank_in];
            rdata_q <= '0;
            beat_q  <= '0;
            cnt_q   <= '0;
            phase_q <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt_q == tsu_q) begin
            cnt_q   <= '0;
            phase_q <= PH_STROBE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt_q == tst_q) begin
            if (!wait_s) begin
              if (!we_q) rdata_q <= rdata_q | rd_piece;
              cnt_q   <= '0;
              phase_q <= PH_HOLD;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q == tho_q) begin
            cnt_q <= '0;
            if (last_beat) begin
              phase_q <= PH_RESP;
            end else begin
              beat_q  <= beat_q + 1'b1;
              phase_q <= PH_SETUP;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_RESP: begin
          if (rsp_ready) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign rsp_valid = (phase_q == PH_RESP);
  assign rsp_rdata = rdata_q;
  assign io_addr   = beat_addr;
  assign io_rd_n   = !((phase_q == PH_STROBE) && !we_q);
  assign io_wr_n   = !((phase_q == PH_STROBE) && we_q);
  assign io_doe    = active && we_q;
  assign io_dout   = io_doe ? beat_wdata : '0;

endmodule

// File: rtl/eio_bank_ctrl_chk.sv
module eio_bank_ctrl_chk #(
  parameter int AW  = 21,
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [31:0]    rsp_rdata,
  input logic [AW-1:0]  io_addr,
  input logic [NCS-1:0] io_cs_n,
  input logic           io_rd_n,
  input logic           io_wr_n,
  input logic           io_doe
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (io_cs_n == '1 && io_rd_n && io_wr_n && !io_doe && !rsp_valid && req_ready)); // R1

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~io_cs_n)); // R2

  AST_STROBE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd_n || !io_wr_n) |-> (io_cs_n != '1)); // R2

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!io_rd_n && !io_wr_n)); // R9

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr_n |-> io_doe); // R9

  AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd_n |-> !io_doe); // R9

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R8

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R8

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd_n && $past(!io_rd_n)) |-> $stable(io_addr)); // R11

endmodule

bind eio_bank_ctrl eio_bank_ctrl_chk #(.AW(AW), .NCS(NCS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .io_addr   (io_addr),
  .io_cs_n   (io_cs_n),
  .io_rd_n   (io_rd_n),
  .io_wr_n   (io_wr_n),
  .io_doe    (io_doe)
);

// File: tb/eio_bank_ctrl_tb_top.sv
module eio_bank_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 12;
  localparam int BANK_BIT   = 11;
  localparam int CS_BIT     = 10;
  localparam int TW         = 3;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          req_write;
  logic [31:0]   req_wdata;
  logic          rsp_valid;
  logic          rsp_ready;
  logic [31:0]   rsp_rdata;
  logic [1:0]    cfg_wide;
  logic [2*TW-1:0] cfg_setup, cfg_strobe, cfg_hold;
  logic [AW-1:0] io_addr;
  logic [3:0]    io_cs_n;
  logic          io_rd_n, io_wr_n;
  logic [15:0]   io_dout;
  logic          io_doe;
  logic [15:0]   io_din;
  logic          io_wait;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;
  string cur_tag  = "R1";
  int    strobe_cnt = 0;
  int    wait_len = 0;
  int    wcnt = 0;

  eio_bank_ctrl #(.AW(AW), .BANK_BIT(BANK_BIT), .CS_BIT(CS_BIT), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cfg_wide(cfg_wide), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
    .io_addr(io_addr), .io_cs_n(io_cs_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .io_dout(io_dout), .io_doe(io_doe), .io_din(io_din), .io_wait(io_wait)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // peripheral: data derived from address, marker value outside the read strobe
  function automatic logic [15:0] dev16(input int a);
    logic [7:0] lo;
    lo = 8'(a);
    return {lo ^ 8'hA5, lo + 8'h3C};
  endfunction

  assign io_din = !io_rd_n ? dev16(int'(io_addr)) : 16'hDEAD;

  function automatic int nbeats_of(input bit wide, input int size);
    if (!wide) return (size == 0) ? 1 : (size == 1) ? 2 : 4;
    return (size >= 2) ? 2 : 1;
  endfunction

  function automatic logic [31:0] exp_read(input int base, input int size, input bit wide);
    logic [31:0] r;
    logic [15:0] t;
    r = '0;
    if (!wide) begin
      for (int k = 0; k < nbeats_of(wide, size); k++) begin
        t = dev16(base + k);
        r = r | (32'(t[7:0]) << (8*k));
      end
    end else if (size == 0) begin
      t = dev16(base);
      r = (base % 2 == 1) ? 32'(t[15:8]) : 32'(t[7:0]);
    end else if (size == 1) begin
      r = 32'(dev16(base));
    end else begin
      r = 32'(dev16(base)) | (32'(dev16(base + 2)) << 16);
    end
    return r;
  endfunction

  function automatic logic [15:0] wlane(input bit wide, input int size, input logic [31:0] wd, input int k);
    logic [7:0] b;
    if (!wide || size == 0) begin
      b = wd[8*k +: 8];
      return {b, b};
    end
    if (size == 1) return wd[15:0];
    return wd[16*k +: 16];
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (section %s) actual=%h expected=%h", what, cur_tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_ph, m_cnt, m_beat, m_nb, m_S, m_W, m_H, m_sel, ws1, ws2;
  bit          m_we;
  logic [31:0] m_rd;
  int          qa[$];
  logic [15:0] qd[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_beat = 0; m_nb = 0; m_we = 0; m_rd = '0;
      m_S = 1; m_W = 1; m_H = 1; m_sel = 0; ws1 = 0; ws2 = 0;
      qa.delete(); qd.delete();
    end else begin
      int w_now, bank, base, sz;
      bit wide;
      w_now = ws2;
      ws2 = ws1;
      ws1 = int'(io_wait);
      case (m_ph)
        0: if (req_valid) begin
          base = int'(req_addr);
          sz   = int'(req_size);
          bank = int'(req_addr[BANK_BIT]);
          wide = cfg_wide[bank];
          m_sel = bank*2 + int'(req_addr[CS_BIT]);
          m_S = int'(cfg_setup[bank*TW +: TW]) + 1;
          m_W = int'(cfg_strobe[bank*TW +: TW]) + 1;
          m_H = int'(cfg_hold[bank*TW +: TW]) + 1;
          m_we = req_write;
          m_nb = nbeats_of(wide, sz);
          qa.delete(); qd.delete();
          for (int k = 0; k < m_nb; k++) begin
            if (!wide) qa.push_back(base + k);
            else if (sz >= 2) qa.push_back(base + 2*k);
            else qa.push_back(base);
            qd.push_back(wlane(wide, sz, req_wdata, k));
          end
          m_rd = m_we ? 32'h0 : exp_read(base, sz, wide);
          m_ph = 1; m_cnt = 0; m_beat = 0;
        end
        1: if (m_cnt == m_S - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
        2: begin
          if (m_cnt < m_W - 1) m_cnt++;
          else if (w_now == 0) begin m_ph = 3; m_cnt = 0; end
        end
        3: if (m_cnt == m_H - 1) begin
          m_cnt = 0;
          if (m_beat == m_nb - 1) m_ph = 4;
          else begin m_beat++; m_ph = 1; end
        end else m_cnt++;
        4: if (rsp_ready) m_ph = 0;
        default: m_ph = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit act;
      logic [3:0] ecs;
      act = (m_ph >= 1 && m_ph <= 3);
      ecs = act ? ~(4'b1 << m_sel) : 4'hF;
      chk(io_cs_n == ecs, "R2 chip select", 32'(io_cs_n), 32'(ecs));
      chk(io_rd_n == !(m_ph == 2 && !m_we), "R3 read strobe phase", 32'(io_rd_n), 32'(!(m_ph == 2 && !m_we)));
      chk(io_wr_n == !(m_ph == 2 && m_we), "R9 write strobe phase", 32'(io_wr_n), 32'(!(m_ph == 2 && m_we)));
      chk(io_doe == (act && m_we), "R9 drive enable", 32'(io_doe), 32'(act && m_we));
      if (act) chk(io_addr == AW'(qa[m_beat]), "R11 beat address", 32'(io_addr), 32'(AW'(qa[m_beat])));
      if (act && m_we) chk(io_dout == qd[m_beat], "R5 write lanes", 32'(io_dout), 32'(qd[m_beat]));
      chk(req_ready == (m_ph == 0), "R8 req_ready", 32'(req_ready), 32'(m_ph == 0));
      chk(rsp_valid == (m_ph == 4), "R8 rsp_valid", 32'(rsp_valid), 32'(m_ph == 4));
      if (m_ph == 4) chk(rsp_rdata == m_rd, "R7 response data", rsp_rdata, m_rd);
    end
  end

  // strobe cycle counter and wait generator
  always @(negedge clk) begin
    if (!io_rd_n || !io_wr_n) strobe_cnt++;
    if (io_cs_n != 4'hF) begin
      if (wcnt < wait_len) begin io_wait = 1'b1; wcnt++; end
      else io_wait = 1'b0;
    end else begin
      io_wait = 1'b0;
      wcnt = 0;
    end
  end

  task automatic xfer(input int addr, input int size, input bit we, input logic [31:0] wd,
                      input int rdelay, input bit poke);
    int bank, wexp;
    bit wide0;
    logic [1:0] sv_w;
    logic [2*TW-1:0] sv_s, sv_t, sv_h;
    bank  = (addr >> BANK_BIT) & 1;
    wide0 = cfg_wide[bank];
    wexp  = nbeats_of(wide0, size) * (int'(cfg_strobe[bank*TW +: TW]) + 1);
    @(negedge clk);
    strobe_cnt = 0;
    req_valid = 1'b1; req_addr = AW'(addr); req_size = 2'(size);
    req_write = we; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    sv_w = cfg_wide; sv_s = cfg_setup; sv_t = cfg_strobe; sv_h = cfg_hold;
    if (poke) begin
      cfg_wide = ~cfg_wide; cfg_setup = '1; cfg_strobe = '1; cfg_hold = '1;
    end
    while (!rsp_valid) @(negedge clk);
    repeat (rdelay) @(negedge clk);
    if (!we) chk(rsp_rdata == exp_read(addr, size, wide0),
                 wide0 ? "R6 read assembly" : "R5 read assembly",
                 rsp_rdata, exp_read(addr, size, wide0));
    else chk(rsp_rdata == 32'h0, "R7 write response zero", rsp_rdata, 32'h0);
    if (wait_len == 0)
      chk(strobe_cnt == wexp, poke ? "R10 latched strobe width" : "R3 strobe cycles",
          32'(strobe_cnt), 32'(wexp));
    else
      chk(strobe_cnt > wexp, "R4 strobe stretched by wait", 32'(strobe_cnt), 32'(wexp + 1));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (poke) begin
      cfg_wide = sv_w; cfg_setup = sv_s; cfg_strobe = sv_t; cfg_hold = sv_h;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired (section %s) actual=%0d expected=%0d", cur_tag, 150000, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_wdata = '0; rsp_ready = 1'b0; io_wait = 1'b0;
    cfg_wide   = 2'b10;               // bank1 16-bit, bank0 8-bit
    cfg_setup  = {3'd2, 3'd0};
    cfg_strobe = {3'd0, 3'd1};
    cfg_hold   = {3'd1, 3'd0};
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk(io_cs_n == 4'hF, "R1 reset chip selects", 32'(io_cs_n), 32'hF);
    chk(io_rd_n && io_wr_n, "R1 reset strobes", 32'({io_rd_n, io_wr_n}), 32'h3);
    chk(!io_doe && !rsp_valid, "R1 reset doe/rsp_valid", 32'({io_doe, rsp_valid}), 32'h0);
    chk(req_ready, "R1 reset req_ready", 32'(req_ready), 32'h1);
    rst_n = 1'b1;

    cur_tag = "R6";
    xfer(12'h810, 1, 1'b1, 32'h1234ABCD, 0, 0);
    xfer(12'h810, 2, 1'b0, 32'h0, 0, 0);
    xfer(12'h813, 0, 1'b0, 32'h0, 0, 0);
    xfer(12'h812, 0, 1'b0, 32'h0, 0, 0);
    xfer(12'h814, 0, 1'b1, 32'h00000077, 0, 0);
    xfer(12'h818, 2, 1'b1, 32'hCAFE5A5A, 0, 0);

    cur_tag = "R5";
    xfer(12'h020, 2, 1'b1, 32'hA1B2C3D4, 0, 0);
    xfer(12'h020, 2, 1'b0, 32'h0, 0, 0);
    xfer(12'h031, 1, 1'b0, 32'h0, 0, 0);
    xfer(12'h005, 0, 1'b0, 32'h0, 0, 0);
    xfer(12'h040, 1, 1'b1, 32'h0000BEEF, 0, 0);

    cur_tag = "R2";
    xfer(12'h440, 0, 1'b0, 32'h0, 0, 0);
    xfer(12'hC40, 1, 1'b0, 32'h0, 0, 0);
    xfer(12'hC44, 2, 1'b1, 32'h01020304, 0, 0);

    cur_tag = "R3";
    cfg_setup = '1; cfg_strobe = '1; cfg_hold = '1;
    xfer(12'h060, 2, 1'b0, 32'h0, 0, 0);
    xfer(12'h860, 2, 1'b1, 32'h55AA33CC, 0, 0);
    cfg_setup = '0; cfg_strobe = '0; cfg_hold = '0;
    xfer(12'h070, 2, 1'b1, 32'h89ABCDEF, 0, 0);
    xfer(12'h870, 0, 1'b0, 32'h0, 0, 0);
    cfg_setup = {3'd2, 3'd0}; cfg_strobe = {3'd0, 3'd1}; cfg_hold = {3'd1, 3'd0};

    cur_tag = "R4";
    wait_len = 4;
    xfer(12'h081, 1, 1'b0, 32'h0, 0, 0);
    cfg_strobe = {3'd2, 3'd1};
    xfer(12'h880, 1, 1'b1, 32'h00004321, 0, 0);
    wait_len = 0;
    cfg_strobe = {3'd0, 3'd1};

    cur_tag = "R8";
    xfer(12'h090, 2, 1'b0, 32'h0, 5, 0);
    xfer(12'h890, 1, 1'b0, 32'h0, 3, 0);

    cur_tag = "R10";
    xfer(12'h0A0, 2, 1'b0, 32'h0, 0, 1);
    xfer(12'h8A0, 2, 1'b1, 32'hF00DFACE, 0, 1);

    cur_tag = "R7";
    xfer(12'h0B3, 0, 1'b0, 32'h0, 1, 0);
    xfer(12'h8B2, 2, 1'b0, 32'h0, 0, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule